// File: doc/BRIEF.md
# Write-Protect and Status Indicator Controller

This block decides when a flash array may be written. An active-low switch asks for protection. The switch is first synchronized to the clock and then debounced. A configuration bit can turn the whole protection feature on or off. When protection is active, the host side sees a protected status bit, and writes to the configuration data area are blocked.

The drive to the flash write-protect pin is not applied at once. It waits until any transfer in flight and any pending internal operation have finished, so that no data is lost part-way through. Releasing the switch removes protection at once, even if work is still under way, because nothing is at risk in that direction.

The block also runs two open-drain style indicators. Each indicator is an output enable with a data value that is always low. The activity indicator is enabled from the start of a transfer to its end. The ready indicator is enabled while initialization is reported as done.

Top module: `wprot_led_ctrl`

## Requirements
- R1: With the feature enabled and the debounced switch low, `prot_status` and `cfg_wr_block` are both 1 on the cycle after the debounced switch goes low.
- R2: With the feature enabled, the debounced switch low and no work in progress, `flash_wp_n` is driven to 0.
- R3: While a transfer is active, a transfer is starting, or `op_pending` is 1, `flash_wp_n` does not fall. It falls on the first cycle after all such work is over.
- R4: When the debounced switch returns high, `prot_status`, `cfg_wr_block` and the drive on `flash_wp_n` all clear on the next cycle, whether or not work is in progress.
- R5: With `cfg_wp_en` at 0, the switch is ignored: `flash_wp_n` stays 1 and `prot_status` stays 0. If `cfg_wp_en` is cleared while protection is active, both clear on the next cycle.
- R6: `act_led_oe` becomes 1 on the cycle after an `xfer_start` pulse and becomes 0 on the cycle after an `xfer_end` pulse. `act_led_dat` is always 0.
- R7: `rdy_led_oe` follows `init_done` with a delay of one cycle. `rdy_led_dat` is always 0.
- R8: The switch passes through two synchronizer flops. The debounced level changes only after the synchronized level has differed from it for DEB_CYCLES cycles in a row. A shorter pulse has no effect on any output.
- R9: During and after reset, `flash_wp_n` = 1, `prot_status` = 0, `cfg_wr_block` = 0, both indicator enables are 0, and the debounced switch is taken as released.
- R10: If `xfer_start` and `xfer_end` are asserted in the same cycle, the start wins and `act_led_oe` becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_wp_n | input | 1 | Write-protect switch, active low, asynchronous to the clock |
| cfg_wp_en | input | 1 | Enables the write-protection feature |
| xfer_start | input | 1 | One-cycle pulse at the start of a transfer |
| xfer_end | input | 1 | One-cycle pulse at the end of a transfer |
| op_pending | input | 1 | An internal operation is still outstanding |
| init_done | input | 1 | Power-up initialization has finished |
| flash_wp_n | output | 1 | Write-protect drive to the flash, low means protected |
| prot_status | output | 1 | Protected status reported to the host side |
| cfg_wr_block | output | 1 | Blocks writes to the configuration data area |
| act_led_oe | output | 1 | Output enable of the activity indicator |
| act_led_dat | output | 1 | Data value of the activity indicator, always 0 |
| rdy_led_oe | output | 1 | Output enable of the ready indicator |
| rdy_led_dat | output | 1 | Data value of the ready indicator, always 0 |

## Verification
The assertions assume that `xfer_start` and `xfer_end` are single-cycle pulses. They also assume that `op_pending`, `cfg_wp_en` and `init_done` are synchronous to the clock, so only the switch input may change at any time. The stimulus changes every input only on the falling edge of the clock. It produces transfers only as start/end pulse pairs, and holds each switch level for a known number of cycles, either above or below the debounce length. A cycle-by-cycle model compares every output on every clock, so deferral, immediate release and the enable gating are each seen at the exact cycle where they take effect.

// File: rtl/wpi_pkg.sv
package wpi_pkg;
    typedef struct packed {
        logic prot;
        logic drive;
    } prot_state_t;

    typedef struct packed {
        logic xfer;
        logic rdy;
    } ind_state_t;
endpackage

// File: rtl/wpi_switch_filter.sv
module wpi_switch_filter #(
    parameter int DEB_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_n,
    output logic level_n
);
    localparam int CW = $clog2(DEB_CYCLES + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic          stable;
        logic [CW-1:0] cnt;
    } filt_state_t;

    filt_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[0], raw_n};
        if (s_q.sync[1] != s_q.stable) begin
            if (s_q.cnt == CW'(DEB_CYCLES - 1)) begin
                s_d.stable = s_q.sync[1];
                s_d.cnt    = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end else begin
            s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.sync   <= 2'b11;
            s_q.stable <= 1'b1;
            s_q.cnt    <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign level_n = s_q.stable;
endmodule

// File: rtl/wpi_protect.sv
module wpi_protect
    import wpi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sw_on,
    input  logic enable,
    input  logic busy,
    output logic prot,
    output logic drive
);
    prot_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (enable && sw_on) begin
            s_d.prot  = 1'b1;
            s_d.drive = s_q.drive | ~busy;
        end else begin
            s_d.prot  = 1'b0;
            s_d.drive = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign prot  = s_q.prot;
    assign drive = s_q.drive;
endmodule

// File: rtl/wpi_indicators.sv
module wpi_indicators
    import wpi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic done,
    input  logic init_ok,
    output logic xfer_on,
    output logic rdy_on
);
    ind_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (start)     s_d.xfer = 1'b1;
        else if (done) s_d.xfer = 1'b0;
        s_d.rdy = init_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign xfer_on = s_q.xfer;
    assign rdy_on  = s_q.rdy;
endmodule

// File: rtl/wprot_led_ctrl.sv
module wprot_led_ctrl #(
    parameter int DEB_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_wp_n,
    input  logic cfg_wp_en,
    input  logic xfer_start,
    input  logic xfer_end,
    input  logic op_pending,
    input  logic init_done,
    output logic flash_wp_n,
    output logic prot_status,
    output logic cfg_wr_block,
    output logic act_led_oe,
    output logic act_led_dat,
    output logic rdy_led_oe,
    output logic rdy_led_dat
);
    logic sw_level_n;
    logic xfer_on;
    logic prot;
    logic drive;
    logic busy;

    wpi_switch_filter #(.DEB_CYCLES(DEB_CYCLES)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_n   (sw_wp_n),
        .level_n (sw_level_n)
    );

    wpi_indicators u_ind (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (xfer_start),
        .done    (xfer_end),
        .init_ok (init_done),
        .xfer_on (xfer_on),
        .rdy_on  (rdy_led_oe)
    );

    assign busy = xfer_on | xfer_start | op_pending;

    wpi_protect u_prot (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_on  (~sw_level_n),
        .enable (cfg_wp_en),
        .busy   (busy),
        .prot   (prot),
        .drive  (drive)
    );

    assign flash_wp_n   = ~drive;
    assign prot_status  = prot;
    assign cfg_wr_block = prot;
    assign act_led_oe   = xfer_on;
    assign act_led_dat  = 1'b0;
    assign rdy_led_dat  = 1'b0;
endmodule

// File: rtl/wpi_checker.sv
module wpi_checker (
    input logic clk,
    input logic rst_n,
    input logic cfg_wp_en,
    input logic xfer_start,
    input logic xfer_end,
    input logic op_pending,
    input logic init_done,
    input logic flash_wp_n,
    input logic prot_status,
    input logic act_led_oe,
    input logic rdy_led_oe
);
    // R5: a disabled feature leaves protection off on the next cycle
    a_r5_disabled_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wp_en |=> (!prot_status && flash_wp_n));

    // R3: the flash drive falls only after a cycle with no work in progress
    a_r3_defer_drive: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flash_wp_n) |-> $past(!op_pending && !act_led_oe && !xfer_start));

    // R2: the flash drive is never active without the protected status
    a_r2_drive_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_wp_n |-> prot_status);

    // R4: when the status clears, the flash drive is released in the same cycle
    a_r4_release_together: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_status) |-> flash_wp_n);

    // R6, R10: a start pulse turns the activity indicator on
    a_r6_start_on: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> act_led_oe);

    // R6: an end pulse without a start turns the activity indicator off
    a_r6_end_off: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_end && !xfer_start) |=> !act_led_oe);

    // R7: the ready indicator follows the initialization flag
    a_r7_ready_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rdy_led_oe == $past(init_done)));
endmodule

bind wprot_led_ctrl wpi_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wp_en   (cfg_wp_en),
    .xfer_start  (xfer_start),
    .xfer_end    (xfer_end),
    .op_pending  (op_pending),
    .init_done   (init_done),
    .flash_wp_n  (flash_wp_n),
    .prot_status (prot_status),
    .act_led_oe  (act_led_oe),
    .rdy_led_oe  (rdy_led_oe)
);

// File: tb/wprot_led_ctrl_tb.sv
module wprot_led_ctrl_tb;
    localparam int DEB = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_wp_n = 1'b1;
    logic cfg_wp_en = 1'b0;
    logic xfer_start = 1'b0;
    logic xfer_end = 1'b0;
    logic op_pending = 1'b0;
    logic init_done = 1'b0;
    logic flash_wp_n, prot_status, cfg_wr_block;
    logic act_led_oe, act_led_dat, rdy_led_oe, rdy_led_dat;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    wprot_led_ctrl #(.DEB_CYCLES(DEB)) u_dut (
        .clk(clk), .rst_n(rst_n), .sw_wp_n(sw_wp_n), .cfg_wp_en(cfg_wp_en),
        .xfer_start(xfer_start), .xfer_end(xfer_end), .op_pending(op_pending),
        .init_done(init_done), .flash_wp_n(flash_wp_n), .prot_status(prot_status),
        .cfg_wr_block(cfg_wr_block), .act_led_oe(act_led_oe), .act_led_dat(act_led_dat),
        .rdy_led_oe(rdy_led_oe), .rdy_led_dat(rdy_led_dat)
    );

    // reference model
    int pipe[$];
    int m_level = 1;
    int m_run = 0;
    bit m_prot = 0, m_wp = 0, m_act = 0, m_rdy = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            pipe = {1, 1};
            m_level = 1; m_run = 0;
            m_prot = 0; m_wp = 0; m_act = 0; m_rdy = 0;
        end else begin
            int seen;
            bit on, work;
            seen = pipe[0];
            on = (m_level == 0) && cfg_wp_en;
            work = m_act || xfer_start || op_pending;
            m_wp = on && (m_wp || !work);
            m_prot = on;
            m_act = xfer_start ? 1'b1 : (xfer_end ? 1'b0 : m_act);
            m_rdy = init_done;
            if (seen != m_level) begin
                m_run++;
                if (m_run == DEB) begin m_level = seen; m_run = 0; end
            end else m_run = 0;
            void'(pipe.pop_front());
            pipe.push_back(int'(sw_wp_n));
        end
    end

    task automatic chk(string req, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b at cycle %0d", req, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk("R2/R3 flash_wp_n model", flash_wp_n, ~m_wp);
            chk("R1 prot_status model", prot_status, m_prot);
            chk("R1 cfg_wr_block model", cfg_wr_block, m_prot);
            chk("R6 act_led_oe model", act_led_oe, m_act);
            chk("R7 rdy_led_oe model", rdy_led_oe, m_rdy);
            chk("R6 act_led_dat", act_led_dat, 1'b0);
            chk("R7 rdy_led_dat", rdy_led_dat, 1'b0);
        end
        if (cycles > 5000) begin
            bad++; total++;
            $display("FAIL watchdog: got hang expected finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start();
        xfer_start = 1'b1; wait_n(1); xfer_start = 1'b0;
    endtask

    task automatic pulse_end();
        xfer_end = 1'b1; wait_n(1); xfer_end = 1'b0;
    endtask

    initial begin
        wait_n(3);
        // R9: reset values
        chk("R9 flash_wp_n", flash_wp_n, 1'b1);
        chk("R9 prot_status", prot_status, 1'b0);
        chk("R9 act_led_oe", act_led_oe, 1'b0);
        chk("R9 rdy_led_oe", rdy_led_oe, 1'b0);
        rst_n = 1'b1;
        wait_n(2);
        chk("R9 after release", prot_status | ~flash_wp_n, 1'b0);

        // R7
        init_done = 1'b1; wait_n(1);
        chk("R7 ready on", rdy_led_oe, 1'b1);

        // R1/R2: idle press
        cfg_wp_en = 1'b1;
        sw_wp_n = 1'b0; wait_n(DEB + 4);
        chk("R1 protected", prot_status, 1'b1);
        chk("R1 config block", cfg_wr_block, 1'b1);
        chk("R2 flash driven", flash_wp_n, 1'b0);

        // R4: release
        sw_wp_n = 1'b1; wait_n(DEB + 4);
        chk("R4 released", prot_status, 1'b0);
        chk("R4 flash free", flash_wp_n, 1'b1);

        // R3: press during transfer
        pulse_start();
        sw_wp_n = 1'b0; wait_n(DEB + 6);
        chk("R3 status during xfer", prot_status, 1'b1);
        chk("R3 deferred by xfer", flash_wp_n, 1'b1);
        pulse_end();
        chk("R3 still deferred on end cycle", flash_wp_n, 1'b1);
        wait_n(1);
        chk("R3 applied after xfer", flash_wp_n, 1'b0);
        sw_wp_n = 1'b1; wait_n(DEB + 4);

        // R3: pending operation
        op_pending = 1'b1;
        sw_wp_n = 1'b0; wait_n(DEB + 6);
        chk("R3 deferred by pending", flash_wp_n, 1'b1);
        op_pending = 1'b0; wait_n(1);
        chk("R3 applied after pending", flash_wp_n, 1'b0);

        // R4: release while busy
        pulse_start();
        op_pending = 1'b1;
        sw_wp_n = 1'b1; wait_n(DEB + 3);
        chk("R4 release while busy", flash_wp_n, 1'b1);
        chk("R4 status clear while busy", prot_status, 1'b0);
        op_pending = 1'b0;
        pulse_end(); wait_n(1);
        chk("R6 activity off", act_led_oe, 1'b0);

        // R8: short glitch
        sw_wp_n = 1'b0; wait_n(DEB - 2); sw_wp_n = 1'b1; wait_n(DEB + 4);
        chk("R8 glitch ignored status", prot_status, 1'b0);
        chk("R8 glitch ignored flash", flash_wp_n, 1'b1);

        // R5: disabled
        cfg_wp_en = 1'b0;
        sw_wp_n = 1'b0; wait_n(DEB + 4);
        chk("R5 disabled status", prot_status, 1'b0);
        chk("R5 disabled flash", flash_wp_n, 1'b1);
        cfg_wp_en = 1'b1; wait_n(2);
        chk("R5 enable applies", prot_status, 1'b1);
        cfg_wp_en = 1'b0; wait_n(1);
        chk("R5 disable clears status", prot_status, 1'b0);
        chk("R5 disable clears flash", flash_wp_n, 1'b1);
        sw_wp_n = 1'b1; cfg_wp_en = 1'b1; wait_n(DEB + 4);

        // R10: start and end together
        xfer_start = 1'b1; xfer_end = 1'b1; wait_n(1);
        xfer_start = 1'b0; xfer_end = 1'b0;
        chk("R10 start wins", act_led_oe, 1'b1);
        pulse_end();
        chk("R6 end clears", act_led_oe, 1'b0);

        init_done = 1'b0; wait_n(1);
        chk("R7 ready off", rdy_led_oe, 1'b0);
        wait_n(2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule